// File: doc/BRIEF.md
# UART Mode and Modem Control Register

This block holds the byte-wide control register of a UART. A CPU write sets the two modem handshake outputs, the global and modem interrupt enables, the receiver enable and a two-bit path mode. The path mode decides how the serial pins connect to the transmitter and receiver shift logic, which lives outside this block. Normal mode drives the pin from the transmitter. Break mode holds the pin at space. Echo mode passes the input pin straight to the output pin. Loop mode feeds the transmitter back into the receiver for self-test.

The block also watches two modem input lines, clear-to-send and data-set-ready. It synchronizes them and shows their levels on a status read path. It latches a change flag whenever either line toggles, and the CPU clears that flag by reading the modem status. The change flag and the transmitter's completion flag combine, each under its enable bits, into one interrupt line.

Top module: `uart_modem_ctrl`

## Requirements
- R1: After reset the control readback is 0x00, `rts_n` and `dtr_n` are 1, `rx_sdi` is 1, and both `modem_chg` and `intr` are 0.
- R2: Control bit 0 drives `rts_n` and bit 1 drives `dtr_n` with inverted sense: writing 1 gives a low pin, writing 0 gives a high pin, visible the cycle after the write.
- R3: The control readback returns the last written value with bit 7 forced to 0, whatever was written to bit 7. The field positions are: bit 2 global interrupt enable, bits 4:3 path mode, bit 5 receiver enable, bit 6 modem interrupt enable.
- R4: In mode 00 (normal), `sdo` follows `tx_sdo` and the receiver input `rx_sdi` follows `sdi`.
- R5: In mode 01 (break), `sdo` is held at 0 whatever `tx_sdo` does.
- R6: In mode 10 (echo), `sdo` is a combinational copy of `sdi` in the same cycle, and `tx_sdo` has no effect on `sdo`.
- R7: In mode 11 (loop), `sdo` is held at 1, and `rx_sdi` follows `tx_sdo` rather than `sdi`.
- R8: When the receiver enable bit is 0, `rx_sdi` is held at 1 in every mode.
- R9: `msr_lines` (bit 0 clear-to-send, bit 1 data-set-ready) shows each input two clock edges after it changes. `modem_chg` becomes 1 on the third edge after any transition of either line.
- R10: A one-cycle `msr_rd` pulse clears `modem_chg` on the next edge. A transition detected on the same edge wins over the clear.
- R11: `intr` is 1 from `modem_chg` only when both the modem interrupt enable and the global interrupt enable are 1.
- R12: `intr` is 1 from `tx_done` whenever the global interrupt enable is 1, and `intr` is 0 whenever the global interrupt enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| ctrl_rd | output | 8 | Control register readback |
| msr_rd | input | 1 | Modem status read strobe, clears the change flag |
| msr_lines | output | 2 | Synchronized modem line levels |
| modem_chg | output | 1 | Modem line change flag |
| sdi | input | 1 | Serial input pin |
| sdo | output | 1 | Serial output pin |
| tx_sdo | input | 1 | Serial output of the transmitter |
| rx_sdi | output | 1 | Serial input to the receiver |
| tx_done | input | 1 | Transmission-complete flag from the transmitter |
| cts | input | 1 | Clear-to-send modem input |
| dsr | input | 1 | Data-set-ready modem input |
| rts_n | output | 1 | Request-to-send output, active low |
| dtr_n | output | 1 | Data-terminal-ready output, active low |
| intr | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and two modem lines. At these values the exact three-edge latency from a line toggle to the change flag can be checked cycle by cycle. Each of the four path modes is driven with opposing levels on `sdi` and `tx_sdo`, so a wrong routing shows at the pins. The clear-versus-set collision is placed on a single edge, and every combination of the two interrupt enables is tried against both sources.

// File: rtl/uart_mc_pkg.sv
package uart_mc_pkg;

    localparam int unsigned CTRL_W = 8;
    localparam logic        MARK   = 1'b1;
    localparam logic        SPACE  = 1'b0;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_BREAK  = 2'b01,
        MODE_ECHO   = 2'b10,
        MODE_LOOP   = 2'b11
    } path_mode_e;

    // Packed MSB first: bit 7 reserved down to bit 0 request-to-send
    typedef struct packed {
        logic       rsvd;
        logic       mien;
        logic       ren;
        path_mode_e mode;
        logic       ien;
        logic       dtr;
        logic       rts;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        rsvd: 1'b0, mien: 1'b0, ren: 1'b0, mode: MODE_NORMAL,
        ien: 1'b0, dtr: 1'b0, rts: 1'b0
    };

    typedef struct packed {
        logic sdo;
        logic rx_sdi;
    } path_out_t;

    function automatic ctrl_t ctrl_from_bus(input logic [CTRL_W-1:0] d);
        ctrl_t c;
        c      = ctrl_t'(d);
        c.rsvd = 1'b0;
        return c;
    endfunction

    function automatic logic pin_from_bit(input logic asserted);
        return asserted ? SPACE : MARK;
    endfunction

endpackage

// File: rtl/mc_ctrl_reg.sv
module mc_ctrl_reg
    import uart_mc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RESET;
        end else if (wr_en) begin
            ctrl <= ctrl_from_bus(wr_data);
        end
    end

endmodule

// File: rtl/mc_path_mux.sv
module mc_path_mux
    import uart_mc_pkg::*;
(
    input  path_mode_e mode,
    input  logic       ren,
    input  logic       sdi,
    input  logic       tx_sdo,
    output path_out_t  path
);

    logic rx_src;

    always_comb begin
        path.sdo = tx_sdo;
        rx_src   = sdi;
        unique case (mode)
            MODE_NORMAL: begin
                path.sdo = tx_sdo;
                rx_src   = sdi;
            end
            MODE_BREAK: begin
                path.sdo = SPACE;
                rx_src   = sdi;
            end
            MODE_ECHO: begin
                path.sdo = sdi;
                rx_src   = sdi;
            end
            MODE_LOOP: begin
                path.sdo = MARK;
                rx_src   = tx_sdo;
            end
            default: begin
                path.sdo = MARK;
                rx_src   = MARK;
            end
        endcase
        path.rx_sdi = ren ? rx_src : MARK;
    end

endmodule

// File: rtl/mc_line_watch.sv
module mc_line_watch #(
    parameter int unsigned NUM_LINES = 2,
    parameter int unsigned STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lines_in,
    input  logic                 clr,
    output logic [NUM_LINES-1:0] lines_sync,
    output logic                 changed
);

    localparam int unsigned LAST = STAGES - 1;

    logic [NUM_LINES-1:0] stage [STAGES];
    logic [NUM_LINES-1:0] prev;
    logic                 any_edge;

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= lines_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign lines_sync = stage[LAST];
    assign any_edge   = |(lines_sync ^ prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= '0;
            changed <= 1'b0;
        end else begin
            prev <= lines_sync;
            if (any_edge)  changed <= 1'b1;
            else if (clr)  changed <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_modem_ctrl.sv
module uart_modem_ctrl
    import uart_mc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_rd,
    input  logic              msr_rd,
    output logic [1:0]        msr_lines,
    output logic              modem_chg,
    input  logic              sdi,
    output logic              sdo,
    input  logic              tx_sdo,
    output logic              rx_sdi,
    input  logic              tx_done,
    input  logic              cts,
    input  logic              dsr,
    output logic              rts_n,
    output logic              dtr_n,
    output logic              intr
);

    localparam int unsigned MODEM_LINES = 2;

    ctrl_t     ctrl;
    path_out_t path;

    mc_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    mc_path_mux u_mux (
        .mode   (ctrl.mode),
        .ren    (ctrl.ren),
        .sdi    (sdi),
        .tx_sdo (tx_sdo),
        .path   (path)
    );

    mc_line_watch #(
        .NUM_LINES (MODEM_LINES),
        .STAGES    (SYNC_STAGES)
    ) u_watch (
        .clk        (clk),
        .rst        (rst),
        .lines_in   ({dsr, cts}),
        .clr        (msr_rd),
        .lines_sync (msr_lines),
        .changed    (modem_chg)
    );

    assign ctrl_rd = ctrl;
    assign sdo     = path.sdo;
    assign rx_sdi  = path.rx_sdi;
    assign rts_n   = pin_from_bit(ctrl.rts);
    assign dtr_n   = pin_from_bit(ctrl.dtr);
    assign intr    = ctrl.ien & (tx_done | (ctrl.mien & modem_chg));

endmodule

// File: rtl/uart_modem_ctrl_chk.sv
module uart_modem_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] ctrl_rd,
    input logic       msr_rd,
    input logic [1:0] msr_lines,
    input logic       modem_chg,
    input logic       sdi,
    input logic       sdo,
    input logic       tx_sdo,
    input logic       rx_sdi,
    input logic       tx_done,
    input logic       rts_n,
    input logic       dtr_n,
    input logic       intr
);

    // R2
    rts_pin_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rts_n == !$past(wr_data[0])));

    // R2
    dtr_pin_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (dtr_n == !$past(wr_data[1])));

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl_rd == {1'b0, $past(wr_data[6:0])}));

    // R5
    break_low_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rd[4:3] == 2'b01) |-> !sdo);

    // R6
    echo_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rd[4:3] == 2'b10) |-> (sdo == sdi));

    // R7
    loop_route_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rd[4:3] == 2'b11 && ctrl_rd[5]) |-> (sdo && rx_sdi == tx_sdo));

    // R8
    rx_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_rd[5] |-> rx_sdi);

    // R9
    edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (msr_lines != $past(msr_lines)) |=> modem_chg);

    // R10
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (msr_rd && msr_lines == $past(msr_lines)) |=> !modem_chg);

    // R12
    ien_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_rd[2] |-> !intr);

    // R12
    txdone_intr_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rd[2] && tx_done) |-> intr);

    // R11
    modem_intr_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_done && !ctrl_rd[6]) |-> !intr);

endmodule

bind uart_modem_ctrl uart_modem_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ctrl_rd   (ctrl_rd),
    .msr_rd    (msr_rd),
    .msr_lines (msr_lines),
    .modem_chg (modem_chg),
    .sdi       (sdi),
    .sdo       (sdo),
    .tx_sdo    (tx_sdo),
    .rx_sdi    (rx_sdi),
    .tx_done   (tx_done),
    .rts_n     (rts_n),
    .dtr_n     (dtr_n),
    .intr      (intr)
);

// File: tb/tb_uart_modem_ctrl.sv
module tb_uart_modem_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] ctrl_rd;
    logic       msr_rd = 1'b0;
    logic [1:0] msr_lines;
    logic       modem_chg;
    logic       sdi = 1'b1;
    logic       sdo;
    logic       tx_sdo = 1'b1;
    logic       rx_sdi;
    logic       tx_done = 1'b0;
    logic       cts = 1'b0;
    logic       dsr = 1'b0;
    logic       rts_n;
    logic       dtr_n;
    logic       intr;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    uart_modem_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ctrl_rd   (ctrl_rd),
        .msr_rd    (msr_rd),
        .msr_lines (msr_lines),
        .modem_chg (modem_chg),
        .sdi       (sdi),
        .sdo       (sdo),
        .tx_sdo    (tx_sdo),
        .rx_sdi    (rx_sdi),
        .tx_done   (tx_done),
        .cts       (cts),
        .dsr       (dsr),
        .rts_n     (rts_n),
        .dtr_n     (dtr_n),
        .intr      (intr)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "ctrl_rd", ctrl_rd, 8'h00);
        chk("R1", "rts_n", {7'd0, rts_n}, 8'h01);
        chk("R1", "dtr_n", {7'd0, dtr_n}, 8'h01);
        chk("R1", "rx_sdi", {7'd0, rx_sdi}, 8'h01);
        chk("R1", "modem_chg", {7'd0, modem_chg}, 8'h00);
        chk("R1", "intr", {7'd0, intr}, 8'h00);
    endtask

    task automatic t_pins;
        wr(8'h01);
        chk("R2", "rts_n low", {7'd0, rts_n}, 8'h00);
        chk("R2", "dtr_n high", {7'd0, dtr_n}, 8'h01);
        wr(8'h02);
        chk("R2", "rts_n high", {7'd0, rts_n}, 8'h01);
        chk("R2", "dtr_n low", {7'd0, dtr_n}, 8'h00);
    endtask

    task automatic t_readback;
        wr(8'hFF);
        chk("R3", "readback FF", ctrl_rd, 8'h7F);
        wr(8'hA5);
        chk("R3", "readback A5", ctrl_rd, 8'h25);
        wr(8'h00);
    endtask

    task automatic t_normal;
        wr(8'h20);
        for (int i = 0; i < 4; i++) begin
            sdi = i[0]; tx_sdo = i[1];
            #1;
            chk("R4", "sdo", {7'd0, sdo}, {7'd0, i[1]});
            chk("R4", "rx_sdi", {7'd0, rx_sdi}, {7'd0, i[0]});
        end
    endtask

    task automatic t_break;
        wr(8'h28);
        tx_sdo = 1'b1; sdi = 1'b0;
        #1;
        chk("R5", "sdo", {7'd0, sdo}, 8'h00);
        chk("R5", "rx_sdi", {7'd0, rx_sdi}, 8'h00);
    endtask

    task automatic t_echo;
        wr(8'h30);
        tx_sdo = 1'b0; sdi = 1'b1;
        #1;
        chk("R6", "sdo hi", {7'd0, sdo}, 8'h01);
        tx_sdo = 1'b1; sdi = 1'b0;
        #1;
        chk("R6", "sdo lo", {7'd0, sdo}, 8'h00);
    endtask

    task automatic t_loop;
        wr(8'h38);
        tx_sdo = 1'b0; sdi = 1'b1;
        #1;
        chk("R7", "sdo", {7'd0, sdo}, 8'h01);
        chk("R7", "rx_sdi lo", {7'd0, rx_sdi}, 8'h00);
        tx_sdo = 1'b1; sdi = 1'b0;
        #1;
        chk("R7", "rx_sdi hi", {7'd0, rx_sdi}, 8'h01);
    endtask

    task automatic t_ren_off;
        tx_sdo = 1'b0; sdi = 1'b0;
        for (int m = 0; m < 4; m++) begin
            wr({3'b000, m[1:0], 3'b000});
            chk("R8", "rx_sdi gated", {7'd0, rx_sdi}, 8'h01);
        end
        sdi = 1'b1; tx_sdo = 1'b1;
        wr(8'h00);
    endtask

    task automatic t_modem_change;
        @(negedge clk);
        cts = 1'b1;
        @(negedge clk);
        chk("R9", "lines e1", {6'd0, msr_lines}, 8'h00);
        @(negedge clk);
        chk("R9", "lines e2", {6'd0, msr_lines}, 8'h01);
        chk("R9", "chg e2", {7'd0, modem_chg}, 8'h00);
        @(negedge clk);
        chk("R9", "chg e3", {7'd0, modem_chg}, 8'h01);
        msr_rd = 1'b1;
        @(negedge clk);
        msr_rd = 1'b0;
        chk("R10", "cleared", {7'd0, modem_chg}, 8'h00);
        dsr = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", "dsr lines", {6'd0, msr_lines}, 8'h03);
        chk("R9", "dsr chg", {7'd0, modem_chg}, 8'h01);
    endtask

    task automatic t_clear_collide;
        msr_rd = 1'b1;
        @(negedge clk);
        msr_rd = 1'b0;
        chk("R10", "pre clear", {7'd0, modem_chg}, 8'h00);
        cts = 1'b0;
        repeat (2) @(negedge clk);
        msr_rd = 1'b1;
        @(negedge clk);
        msr_rd = 1'b0;
        chk("R10", "set wins", {7'd0, modem_chg}, 8'h01);
        msr_rd = 1'b1;
        @(negedge clk);
        msr_rd = 1'b0;
        chk("R10", "later clear", {7'd0, modem_chg}, 8'h00);
    endtask

    task automatic t_intr;
        dsr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11", "chg set", {7'd0, modem_chg}, 8'h01);
        wr(8'h04);
        chk("R11", "ien only", {7'd0, intr}, 8'h00);
        wr(8'h40);
        chk("R11", "mien only", {7'd0, intr}, 8'h00);
        wr(8'h44);
        chk("R11", "both", {7'd0, intr}, 8'h01);
        msr_rd = 1'b1;
        @(negedge clk);
        msr_rd = 1'b0;
        chk("R11", "after read", {7'd0, intr}, 8'h00);
        wr(8'h04);
        tx_done = 1'b1;
        #1;
        chk("R12", "tx_done ien", {7'd0, intr}, 8'h01);
        wr(8'h40);
        chk("R12", "tx_done no ien", {7'd0, intr}, 8'h00);
        tx_done = 1'b0;
        wr(8'h00);
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_pins;
        t_readback;
        t_normal;
        t_break;
        t_echo;
        t_loop;
        t_ren_off;
        t_modem_change;
        t_clear_collide;
        t_intr;
        report;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report;
    end

endmodule